// File: doc/BRIEF.md
# SAR ADC Track-and-Convert Sequencer

This block paces the sample switch and the bit-by-bit search of a 10-bit successive-approximation converter. It advances on a SAR clock enable tick. Each accepted start event produces exactly one conversion. A 3-bit source select picks the start event. The source is either a software strobe, one of four timer overflow pulses, or the rising edge of an external start pin. The pin is first passed through a two-flop synchronizer.

Two tracking policies are available. With `lp_track` low, the sample switch stays closed whenever no conversion is running, so the conversion starts on the next cycle. With `lp_track` high and an internal source, the switch closes only for a fixed three-tick window after the start event, and the conversion follows at once. With `lp_track` high and the pin as source, the switch follows the synchronized pin level: it is closed while the pin is low, and the rising edge starts the conversion. A sleep request opens the switch in every mode.

The state machine has three states:
- `ST_IDLE`: waiting for a start event.
- `ST_TRACK`: the low-power pre-conversion window.
- `ST_CONV`: the 14-tick convert phase.

It has four transitions:
- IDLE→TRACK: start accepted with `lp_track` high and an internal source.
- IDLE→CONV: start accepted in any other case.
- TRACK→CONV: on the third tick.
- CONV→IDLE: on the fourteenth tick, which also pulses `done` and latches `result`.

Top module: `sar_track_seq`

## Requirements
- R1: While `rst` is high (synchronous, active high), the block returns to idle. After the first clock edge with `rst` low, `busy`, `done` and `conv_phase` read 0, `result` and `trial_code` read 0, and `track_en` reads 1 when `lp_track` and `sleep_req` are low.
- R2: `src_sel` selects the start event as follows:
  - 000: `sw_start`.
  - 001, 010, 011: `tmr_ovf[0]`, `tmr_ovf[1]`, `tmr_ovf[2]`.
  - 101: `tmr_ovf[3]`.
  - 100: the rising edge of the synchronized `conv_pin`.
  - 110 and 111: no event.
  
  Pulses on unselected sources start nothing.
- R3: With `lp_track` low and `sleep_req` low, `track_en` equals the inverse of `conv_phase` at all times. An accepted start goes straight into the convert phase, with no tracking window.
- R4: With `lp_track` high and an internal source, the busy period consists of two parts. First, exactly 3 `sar_tick` ticks have `track_en` high and `conv_phase` low. Then 14 ticks follow in the convert phase, for 17 ticks in total. `track_en` is low whenever that window is not open.
- R5: `conv_pin` goes through a two-flop synchronizer. `busy` rises after the third rising clock edge following a pin rise. A pin held high starts nothing more. With `lp_track` high and the pin selected, `track_en` is 1 exactly while the synchronized pin is low and no conversion runs.
- R6: The convert phase lasts exactly 14 `sar_tick` ticks. `ST_TRACK` and `ST_CONV` advance only on cycles where `sar_tick` is 1. A start is accepted on any cycle, whether or not a tick is present.
- R7: While `sleep_req` is 1, `track_en` is 0 in every mode.
- R8: Timing of `busy` and `done`:
  - `busy` rises in the cycle after a start is accepted.
  - `done` is a one-cycle pulse in the first cycle that `busy` is low again.
  - Start events that arrive while `busy` is high are dropped and not queued.
- R9: The conversion is resolved MSB-first. `trial_code` starts at 1000000000. On each of the first 10 convert ticks, the bit under test is kept if `cmp_in` is 1 and cleared if it is 0, and the next lower bit is set as the new trial. `result` takes the final code only when `done` pulses and holds otherwise. With `cmp_in` = (`trial_code` <= V), the result equals V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sar_tick | input | 1 | SAR clock enable; sequencer phases advance on it |
| src_sel | input | 3 | Start-event source select |
| lp_track | input | 1 | 1 selects the low-power tracking policy |
| sw_start | input | 1 | Software start strobe |
| tmr_ovf | input | 4 | Timer overflow pulses |
| conv_pin | input | 1 | Asynchronous external start pin |
| sleep_req | input | 1 | Sleep/standby request; forces tracking off |
| cmp_in | input | 1 | Comparator result for the current trial code |
| track_en | output | 1 | Closes the sample switch |
| conv_phase | output | 1 | High during the convert phase |
| busy | output | 1 | Conversion sequence in progress |
| done | output | 1 | One-cycle end-of-conversion pulse |
| trial_code | output | 10 | Trial code for the comparison DAC |
| result | output | 10 | Last completed conversion result |

## Verification
The bench counts the ticks spent tracking and converting under a sparse, irregular `sar_tick`. A design that counted clocks instead of ticks, or that stretched the window by one, shows the wrong total. It fires start pulses mid-conversion, and a design that queued them would raise `busy` again after `done`. It also pulses unselected timers and uses the two unused codes, which catches a loose source decoder. It times the pin path edge by edge, so a missing or extra synchronizer stage shifts the rise of `busy` by a cycle. It drives the comparator from an ideal model, so a wrong bit order or a skipped trial bit gives a result that differs from the applied level, including at 0 and full scale.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRACK = 2'd1,
        ST_CONV  = 2'd2
    } seq_state_t;

    // start-event source codes
    localparam logic [2:0] SRC_SOFT  = 3'b000;
    localparam logic [2:0] SRC_TMR_A = 3'b001;
    localparam logic [2:0] SRC_TMR_B = 3'b010;
    localparam logic [2:0] SRC_TMR_C = 3'b011;
    localparam logic [2:0] SRC_PIN   = 3'b100;
    localparam logic [2:0] SRC_TMR_D = 3'b101;

endpackage

// File: rtl/sar_trig_front.sv
module sar_trig_front
    import sar_seq_pkg::*;
#(
    parameter int N_TIMERS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          src_sel,
    input  logic                sw_start,
    input  logic [N_TIMERS-1:0] tmr_ovf,
    input  logic                pin_raw,
    output logic                trig_hit,
    output logic                src_is_pin,
    output logic                pin_level
);

    // synchronizer stages plus one history flop for edge detection
    logic [SYNC_STAGES:0]  pin_pipe;
    logic                  pin_prev;
    logic                  pin_rise;
    logic [N_TIMERS-1:0]   tmr_hit;

    function automatic logic [2:0] tmr_code(input int idx);
        case (idx)
            0:       return SRC_TMR_A;
            1:       return SRC_TMR_B;
            2:       return SRC_TMR_C;
            default: return SRC_TMR_D;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) pin_pipe <= '0;
        else     pin_pipe <= {pin_pipe[SYNC_STAGES-1:0], pin_raw};
    end

    assign pin_level  = pin_pipe[SYNC_STAGES-1];
    assign pin_prev   = pin_pipe[SYNC_STAGES];
    assign pin_rise   = pin_level & ~pin_prev;
    assign src_is_pin = (src_sel == SRC_PIN);

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
        assign tmr_hit[g] = tmr_ovf[g] && (src_sel == tmr_code(g));
    end

    assign trig_hit = (|tmr_hit)
                    | ((src_sel == SRC_SOFT) & sw_start)
                    | (src_is_pin & pin_rise);

    AST_PIN_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pin_rise |=> !pin_rise); // R5

    AST_PIN_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        (trig_hit && src_sel == SRC_PIN) |-> (pin_level && !pin_prev)); // R2

endmodule

// File: rtl/sar_core.sv
module sar_core #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                step_en,
    input  logic                cmp_in,
    input  logic                latch,
    output logic [RES_BITS-1:0] trial_code,
    output logic [RES_BITS-1:0] result
);

    localparam logic [RES_BITS-1:0] MSB_ONE = RES_BITS'(1) << (RES_BITS-1);

    logic [RES_BITS-1:0] work_q;
    logic [RES_BITS-1:0] ptr_q;
    logic [RES_BITS-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            ptr_q  <= '0;
            res_q  <= '0;
        end else begin
            if (load) begin
                work_q <= MSB_ONE;
                ptr_q  <= MSB_ONE;
            end else if (step_en && (|ptr_q)) begin
                // keep or drop the bit under test, then set the next trial bit
                work_q <= (cmp_in ? work_q : (work_q & ~ptr_q)) | (ptr_q >> 1);
                ptr_q  <= ptr_q >> 1;
            end
            if (latch) res_q <= work_q;
        end
    end

    assign trial_code = work_q;
    assign result     = res_q;

    AST_TRIAL_PTR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ptr_q)); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !latch |=> $stable(result)); // R9

endmodule

// File: rtl/sar_track_seq.sv
module sar_track_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS    = 10,
    parameter int TRACK_TICKS = 3,
    parameter int CONV_TICKS  = 14,
    parameter int N_TIMERS    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sar_tick,
    input  logic [2:0]          src_sel,
    input  logic                lp_track,
    input  logic                sw_start,
    input  logic [N_TIMERS-1:0] tmr_ovf,
    input  logic                conv_pin,
    input  logic                sleep_req,
    input  logic                cmp_in,
    output logic                track_en,
    output logic                conv_phase,
    output logic                busy,
    output logic                done,
    output logic [RES_BITS-1:0] trial_code,
    output logic [RES_BITS-1:0] result
);

    localparam int MAX_TICKS = (CONV_TICKS > TRACK_TICKS) ? CONV_TICKS : TRACK_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS);
    localparam logic [CNT_W-1:0] TRACK_LAST = CNT_W'(TRACK_TICKS - 1);
    localparam logic [CNT_W-1:0] CONV_LAST  = CNT_W'(CONV_TICKS - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_q, done_d;
    logic             trig_hit, src_is_pin, pin_level;
    logic             sar_load, sar_latch;

    sar_trig_front #(
        .N_TIMERS    (N_TIMERS),
        .SYNC_STAGES (2)
    ) u_front (
        .clk        (clk),
        .rst        (rst),
        .src_sel    (src_sel),
        .sw_start   (sw_start),
        .tmr_ovf    (tmr_ovf),
        .pin_raw    (conv_pin),
        .trig_hit   (trig_hit),
        .src_is_pin (src_is_pin),
        .pin_level  (pin_level)
    );

    sar_core #(
        .RES_BITS (RES_BITS)
    ) u_core (
        .clk        (clk),
        .rst        (rst),
        .load       (sar_load),
        .step_en    (conv_phase && sar_tick),
        .cmp_in     (cmp_in),
        .latch      (sar_latch),
        .trial_code (trial_code),
        .result     (result)
    );

    // next state
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        done_d    = 1'b0;
        sar_load  = 1'b0;
        sar_latch = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_hit) begin
                    sar_load = 1'b1;
                    cnt_d    = '0;
                    state_d  = (lp_track && !src_is_pin) ? ST_TRACK : ST_CONV;
                end
            end
            ST_TRACK: begin
                if (sar_tick) begin
                    if (cnt_q == TRACK_LAST) begin
                        state_d = ST_CONV;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_CONV: begin
                if (sar_tick) begin
                    if (cnt_q == CONV_LAST) begin
                        state_d   = ST_IDLE;
                        cnt_d     = '0;
                        done_d    = 1'b1;
                        sar_latch = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        conv_phase = (state_q == ST_CONV);
        done       = done_q;
        if (sleep_req)
            track_en = 1'b0;
        else if (!lp_track)
            track_en = (state_q != ST_CONV);
        else if (src_is_pin)
            track_en = !pin_level && (state_q != ST_CONV);
        else
            track_en = (state_q == ST_TRACK);
    end

    AST_DONE_CLOSES_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_CONV_OPENS_SWITCH: assert property (@(posedge clk) disable iff (rst)
        conv_phase |-> !track_en); // R3

    AST_SLEEP_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> !track_en); // R7

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        (!sar_tick && busy) |=> (busy && $stable(conv_phase))); // R6

    AST_CONV_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (rst)
        conv_phase |-> busy); // R6

endmodule

// File: tb/sar_track_seq_test.sv
module sar_track_seq_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       sar_tick;
    logic [2:0] src_sel;
    logic       lp_track;
    logic       sw_start;
    logic [3:0] tmr_ovf;
    logic       conv_pin;
    logic       sleep_req;
    logic       cmp_in;
    logic       track_en, conv_phase, busy, done;
    logic [9:0] trial_code, result;
    logic [9:0] vin;

    int total = 0;
    int bad   = 0;
    int seed_init;

    always #10 clk = ~clk;

    // ideal comparator: keep the trial bit while trial <= input level
    assign cmp_in = (trial_code <= vin);

    sar_track_seq uut (
        .clk        (clk),
        .rst        (rst),
        .sar_tick   (sar_tick),
        .src_sel    (src_sel),
        .lp_track   (lp_track),
        .sw_start   (sw_start),
        .tmr_ovf    (tmr_ovf),
        .conv_pin   (conv_pin),
        .sleep_req  (sleep_req),
        .cmp_in     (cmp_in),
        .track_en   (track_en),
        .conv_phase (conv_phase),
        .busy       (busy),
        .done       (done),
        .trial_code (trial_code),
        .result     (result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // expected switch state for an internal-source run
    function automatic bit exp_track(input bit slp, input bit lp, input bit bsy, input bit cnv);
        if (slp)      return 1'b0;
        else if (!lp) return !cnv;
        else          return bsy && !cnv;
    endfunction

    function automatic int exp_track_ticks(input bit lp, input logic [2:0] sel);
        return (lp && sel != 3'b100) ? 3 : 0;
    endfunction

    task automatic drive_source(input logic [2:0] sel);
        case (sel)
            3'b000:  sw_start   = 1'b1;
            3'b001:  tmr_ovf[0] = 1'b1;
            3'b010:  tmr_ovf[1] = 1'b1;
            3'b011:  tmr_ovf[2] = 1'b1;
            3'b101:  tmr_ovf[3] = 1'b1;
            default: ;
        endcase
    endtask

    // pulse every internal source except the selected one
    task automatic drive_others(input logic [2:0] sel);
        sw_start = (sel != 3'b000);
        tmr_ovf  = {sel != 3'b101, sel != 3'b011, sel != 3'b010, sel != 3'b001};
    endtask

    task automatic run_conv(input logic [2:0] sel, input bit lp, input logic [9:0] v,
                            input bit slow, input bit slp, input bit spam);
        logic [9:0] prev_res;
        int tr, cv, cyc;
        string treq;
        @(negedge clk);
        src_sel = sel; lp_track = lp; vin = v; sleep_req = slp; sar_tick = 1'b1;
        sw_start = 1'b0; tmr_ovf = '0;
        prev_res = result;
        @(negedge clk);
        drive_source(sel);
        @(negedge clk);
        sw_start = 1'b0; tmr_ovf = '0;
        sar_tick = slow ? (($urandom % 3) == 0) : 1'b1;
        #1;
        chk(busy == 1'b1, "R8 busy after start", busy, 1);
        chk(conv_phase == !(lp), "R3 direct convert when not low-power", conv_phase, !lp);
        treq = slp ? "R7 sleep switch" : (lp ? "R4 window switch" : "R3 continuous switch");
        tr = 0; cv = 0; cyc = 0;
        while (!done && cyc < 400) begin
            chk(track_en == exp_track(slp, lp, busy, conv_phase), treq, track_en,
                exp_track(slp, lp, busy, conv_phase));
            chk(result == prev_res, "R9 result held until done", result, prev_res);
            if (busy && !conv_phase && sar_tick) tr++;
            if (conv_phase && sar_tick) cv++;
            @(negedge clk);
            sw_start = 1'b0; tmr_ovf = '0;
            sar_tick = slow ? (($urandom % 3) == 0) : 1'b1;
            if (spam && (cyc == 2 || cyc == 7)) begin
                sw_start = 1'b1; tmr_ovf = '1;
            end
            #1;
            cyc++;
        end
        chk(done == 1'b1, "R8 done pulse seen", done, 1);
        chk(busy == 1'b0, "R8 busy low with done", busy, 0);
        chk(cv == 14, "R6 convert ticks", cv, 14);
        chk(tr == exp_track_ticks(lp, sel), "R4 track window ticks", tr, exp_track_ticks(lp, sel));
        chk(result == v, "R9 result equals input level", result, v);
        sw_start = 1'b0; tmr_ovf = '0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            chk(busy == 1'b0 && done == 1'b0, "R8 dropped starts not queued", busy, 0);
        end
    endtask

    task automatic unselected(input logic [2:0] sel);
        @(negedge clk);
        src_sel = sel; lp_track = 1'b0; sleep_req = 1'b0;
        @(negedge clk);
        drive_others(sel);
        @(negedge clk);
        sw_start = 1'b0; tmr_ovf = '0;
        #1;
        chk(busy == 1'b0, "R2 unselected source ignored", busy, 0);
        @(negedge clk); #1;
        chk(busy == 1'b0, "R2 unselected source ignored (late)", busy, 0);
    endtask

    task automatic ext_case(input bit lp, input logic [9:0] v);
        int cv;
        @(negedge clk);
        src_sel = 3'b100; lp_track = lp; conv_pin = 1'b0; sar_tick = 1'b1;
        sleep_req = 1'b0; vin = v;
        repeat (4) @(negedge clk);
        #1;
        chk(track_en == 1'b1, "R5 tracking while pin low", track_en, 1);
        @(negedge clk);
        sw_start = 1'b1; tmr_ovf = '1;
        @(negedge clk);
        sw_start = 1'b0; tmr_ovf = '0; conv_pin = 1'b1;
        #1;
        chk(busy == 1'b0, "R2 internal sources ignored with pin selected", busy, 0);
        @(negedge clk); #1;
        chk(busy == 1'b0, "R5 busy still low after first edge", busy, 0);
        chk(track_en == 1'b1, "R5 switch before sync completes", track_en, 1);
        @(negedge clk); #1;
        chk(busy == 1'b0, "R5 busy still low after second edge", busy, 0);
        chk(track_en == !lp, "R5 switch follows synced pin", track_en, !lp);
        @(negedge clk); #1;
        chk(busy == 1'b1, "R5 busy after third edge", busy, 1);
        chk(conv_phase == 1'b1, "R5 pin start converts directly", conv_phase, 1);
        cv = 0;
        for (int k = 0; k < 100 && !done; k++) begin
            if (conv_phase && sar_tick) cv++;
            @(negedge clk); #1;
        end
        chk(cv == 14, "R6 convert ticks on pin start", cv, 14);
        chk(result == v, "R9 pin-started result", result, v);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); #1;
            chk(busy == 1'b0, "R5 held-high pin starts nothing", busy, 0);
        end
        conv_pin = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(track_en == 1'b1, "R5 tracking resumes with pin low", track_en, 1);
    endtask

    initial begin
        #(20 * 200000);
        total++; bad++;
        $display("FAIL R8 watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        seed_init = $urandom(32'd4177);
        rst = 1'b1; sar_tick = 1'b1; src_sel = 3'b000; lp_track = 1'b0;
        sw_start = 1'b0; tmr_ovf = '0; conv_pin = 1'b0; sleep_req = 1'b0; vin = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(busy == 1'b0 && done == 1'b0 && conv_phase == 1'b0, "R1 idle after reset", busy, 0);
        chk(result == 10'd0 && trial_code == 10'd0, "R1 registers cleared", result, 0);
        chk(track_en == 1'b1, "R1 continuous tracking at reset", track_en, 1);

        // R2 decoder: unselected and unused codes
        unselected(3'b000);
        unselected(3'b001);
        unselected(3'b011);
        unselected(3'b101);
        unselected(3'b110);
        unselected(3'b111);

        // directed corners
        run_conv(3'b000, 1'b1, 10'd0,    1'b0, 1'b0, 1'b0);
        run_conv(3'b001, 1'b1, 10'd1023, 1'b0, 1'b0, 1'b1);
        run_conv(3'b010, 1'b0, 10'd512,  1'b1, 1'b0, 1'b1);
        run_conv(3'b101, 1'b1, 10'd511,  1'b1, 1'b1, 1'b0);
        run_conv(3'b011, 1'b0, 10'd341,  1'b0, 1'b1, 1'b0);
        ext_case(1'b1, 10'd700);
        ext_case(1'b0, 10'd45);

        // constrained random
        for (int n = 0; n < 24; n++) begin
            logic [2:0] s;
            case ($urandom % 5)
                0: s = 3'b000;
                1: s = 3'b001;
                2: s = 3'b010;
                3: s = 3'b011;
                default: s = 3'b101;
            endcase
            run_conv(s, 1'($urandom % 2), 10'($urandom % 1024),
                     1'($urandom % 2), 1'(($urandom % 4) == 0), 1'($urandom % 2));
        end

        // R7 sleep during idle, low-power pin mode
        @(negedge clk);
        src_sel = 3'b100; lp_track = 1'b1; sleep_req = 1'b1; conv_pin = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(track_en == 1'b0, "R7 sleep forces switch open", track_en, 0);
        sleep_req = 1'b0;
        @(negedge clk); #1;
        chk(track_en == 1'b1, "R7 switch returns after sleep", track_en, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule